// File: doc/BRIEF.md
# Fractional-Resolution PWM Generator

This block drives a single pulse-width-modulated output at a fixed frequency set by an integer period value: the output repeats every `period_i` clock cycles. The duty input is a fixed-point number. Its integer part gives the base number of high cycles per period. Its fractional part, `FRAC_W` bits wide, decides how many periods of each frame get one extra high cycle. A frame is `M = 2^FRAC_W` consecutive periods.

A window counter steps down once per period through the values M-1 to 0 and then wraps. A period whose window number is below the fractional value is stretched by one high cycle. Over a full frame the average high time is therefore N + m/M cycles. The duty resolution is finer by a factor of M, while the clock and the period stay the same.

All three inputs are taken only on the last cycle of a period. A change made mid-period affects only the periods that follow it, so the output never shows a truncated pulse or a glitch.

Top module: `fpwm_gen`

## Requirements
- R1: The output repeats every P clock cycles, where P is `period_i` when `period_i` is at least 1, and P is 1 when `period_i` is 0.
- R2: The window number of the first period after reset is M-1. Each later period takes the previous window number minus one, modulo M, so window 0 is the last period of each frame.
- R3: A period whose window number w satisfies w < `duty_frac_i` loads a high count D = `duty_int_i` + 1. Any other period loads D = `duty_int_i`. When 0 < D < P, the period has exactly D high cycles.
- R4: Within a period the high cycles form one contiguous run that starts on the first cycle of the period. The output rises only on the first cycle of a period.
- R5: When `duty_int_i` + 1 <= P, the high cycles over the M periods of one frame total M·`duty_int_i` + `duty_frac_i`.
- R6: `period_i`, `duty_int_i` and `duty_frac_i` are sampled only on the last cycle of a period. A change during a period does not alter that period's length or high count.
- R7: A period whose loaded count D is 0 keeps the output low for all of its cycles.
- R8: A period whose loaded count D is P or more keeps the output high for all of its cycles.
- R9: While `rst` is high the output is low from the first clock edge on, and all counters are cleared. The first period begins on the first clock edge at which `rst` is low: the output shows cycle 0 of that period right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | PER_W | Period length P in clock cycles (0 is treated as 1) |
| duty_int_i | input | INT_W | Integer part N of the duty count |
| duty_frac_i | input | FRAC_W | Fractional part m of the duty count, in units of 1/M |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bound checker covers the following on every cycle:
- the window counter steps by exactly one at each period boundary and holds in between;
- the output rises only just after a boundary;
- a period loaded with zero stays low, and a period whose integer part reaches the period length stays high;
- reset forces the output low.

Only the bench's scenarios can show the rest. These are the exact per-period high counts, which depend on the window ordering, the frame totals of M·N + m, the spacing between rising edges, and the fact that a mid-period change of the inputs leaves the running period untouched. The bench sweeps small periods, every integer part up to past the period and every fractional value. It also runs one long configuration of 4000-cycle periods.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    // Default widths for the generator and its parts.
    localparam int unsigned FPWM_PER_W  = 16;
    localparam int unsigned FPWM_INT_W  = 16;
    localparam int unsigned FPWM_FRAC_W = 3;

    // Effective period length: a zero period behaves as a one-cycle period.
    function automatic int unsigned fpwm_eff_period(input int unsigned raw);
        return (raw == 0) ? 1 : raw;
    endfunction

endpackage

// File: rtl/fpwm_period_ctr.sv
module fpwm_period_ctr #(
    parameter int unsigned PER_W = fpwm_pkg::FPWM_PER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] per_i,
    output logic             wrap_o
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } per_st_t;

    per_st_t st_d, st_q;

    // Counts down from P-1 to 0; the zero cycle is the last of a period
    // and is where the next period's length is taken from per_i.
    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            if (per_i == '0) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = per_i - PER_W'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt - PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o = (st_q.cnt == '0);

endmodule

// File: rtl/fpwm_frame_ctr.sv
module fpwm_frame_ctr #(
    parameter int unsigned FRAC_W = fpwm_pkg::FPWM_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [FRAC_W-1:0] win_o,
    output logic [FRAC_W-1:0] win_nx_o
);

    typedef struct packed {
        logic [FRAC_W-1:0] win;
    } frm_st_t;

    frm_st_t st_d, st_q;

    // Reset leaves the window at 0. The first step after reset then
    // wraps it to M-1, so the first period is window M-1.
    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.win = st_q.win - FRAC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o    = st_q.win;
    assign win_nx_o = st_d.win;

endmodule

// File: rtl/fpwm_duty_ctr.sv
module fpwm_duty_ctr #(
    parameter int unsigned CNT_W = fpwm_pkg::FPWM_INT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             pwm;
    } duty_st_t;

    duty_st_t st_d, st_q;

    // rem holds the high cycles left, counting the current one.
    // Reloading at every boundary keeps the output high across the
    // boundary when the count reaches the period length.
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.rem = load_val_i;
        end else if (st_q.rem != '0) begin
            st_d.rem = st_q.rem - CNT_W'(1);
        end
        st_d.pwm = (st_d.rem != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

endmodule

// File: rtl/fpwm_gen.sv
module fpwm_gen #(
    parameter int unsigned PER_W  = fpwm_pkg::FPWM_PER_W,
    parameter int unsigned INT_W  = fpwm_pkg::FPWM_INT_W,
    parameter int unsigned FRAC_W = fpwm_pkg::FPWM_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PER_W-1:0]  period_i,
    input  logic [INT_W-1:0]  duty_int_i,
    input  logic [FRAC_W-1:0] duty_frac_i,
    output logic              pwm_o
);

    localparam int unsigned CNT_W = INT_W + 1;

    logic              per_wrap;
    logic [FRAC_W-1:0] win_cur;
    logic [FRAC_W-1:0] win_nx;
    logic              extra_cnt;
    logic [CNT_W-1:0]  load_val;

    fpwm_period_ctr #(.PER_W(PER_W)) u_period (
        .clk    (clk),
        .rst    (rst),
        .per_i  (period_i),
        .wrap_o (per_wrap)
    );

    fpwm_frame_ctr #(.FRAC_W(FRAC_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .step_i   (per_wrap),
        .win_o    (win_cur),
        .win_nx_o (win_nx)
    );

    // The extra count goes to the windows numbered below the fraction,
    // which gives exactly m stretched periods in every frame.
    always_comb begin
        extra_cnt = (win_nx < duty_frac_i);
        load_val  = {1'b0, duty_int_i} + {{INT_W{1'b0}}, extra_cnt};
    end

    fpwm_duty_ctr #(.CNT_W(CNT_W)) u_duty (
        .clk        (clk),
        .rst        (rst),
        .load_i     (per_wrap),
        .load_val_i (load_val),
        .pwm_o      (pwm_o)
    );

endmodule

// File: rtl/fpwm_gen_chk.sv
module fpwm_gen_chk #(
    parameter int unsigned PER_W  = fpwm_pkg::FPWM_PER_W,
    parameter int unsigned INT_W  = fpwm_pkg::FPWM_INT_W,
    parameter int unsigned FRAC_W = fpwm_pkg::FPWM_FRAC_W
) (
    input logic              clk,
    input logic              rst,
    input logic [PER_W-1:0]  period_i,
    input logic [INT_W-1:0]  duty_int_i,
    input logic [FRAC_W-1:0] duty_frac_i,
    input logic              pwm_o,
    input logic              per_wrap,
    input logic [FRAC_W-1:0] win_cur
);

    // Per-period flags taken at each boundary from the inputs of that cycle.
    logic zero_q;
    logic full_q;
    logic zero_now;
    logic full_now;

    always_comb begin
        zero_now = (duty_int_i == '0) && (duty_frac_i == '0);
        full_now = (32'(duty_int_i) >= fpwm_pkg::fpwm_eff_period(32'(period_i)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b0;
            full_q <= 1'b0;
        end else if (per_wrap) begin
            zero_q <= zero_now;
            full_q <= full_now;
        end
    end

    AST_RST_LOW: assert property (@(posedge clk) rst |=> !pwm_o); // R9

    AST_WIN_STEP: assert property (@(posedge clk) disable iff (rst)
        per_wrap |=> (win_cur == FRAC_W'($past(win_cur) - FRAC_W'(1)))); // R2

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !per_wrap |=> $stable(win_cur)); // R2

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> $past(per_wrap)); // R4

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        zero_q |-> !pwm_o); // R7

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        full_q |-> pwm_o); // R8

endmodule

bind fpwm_gen fpwm_gen_chk #(
    .PER_W  (PER_W),
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .period_i    (period_i),
    .duty_int_i  (duty_int_i),
    .duty_frac_i (duty_frac_i),
    .pwm_o       (pwm_o),
    .per_wrap    (per_wrap),
    .win_cur     (win_cur)
);

// File: tb/test_fpwm_gen.sv
module test_fpwm_gen;

    localparam int PER_W  = 16;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 3;
    localparam int M      = 1 << FRAC_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PER_W-1:0]  period_i = '0;
    logic [INT_W-1:0]  duty_int_i = '0;
    logic [FRAC_W-1:0] duty_frac_i = '0;
    logic              pwm_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    fpwm_gen #(.PER_W(PER_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) i_fpwm_gen (
        .clk         (clk),
        .rst         (rst),
        .period_i    (period_i),
        .duty_int_i  (duty_int_i),
        .duty_frac_i (duty_frac_i),
        .pwm_o       (pwm_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff_p(input int no);
        return (no < 1) ? 1 : no;
    endfunction

    function automatic int load_d(input int n, input int m, input int p);
        int w;
        w = M - 1 - (p % M);
        return n + ((w < m) ? 1 : 0);
    endfunction

    // Reset with the given inputs; returns right after rst is released,
    // so the next falling edge shows cycle 0 of the first period.
    task automatic start_cfg(input int no, input int n, input int m);
        @(negedge clk);
        rst         = 1'b1;
        period_i    = PER_W'(no);
        duty_int_i  = INT_W'(n);
        duty_frac_i = FRAC_W'(m);
        @(negedge clk);
        chk(pwm_o == 1'b0, "R9 output low in reset", int'(pwm_o), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_cfg(input int no, input int n, input int m, input int nper);
        int pe;
        int sum;
        pe  = eff_p(no);
        sum = 0;
        start_cfg(no, n, m);
        for (int p = 0; p < nper; p++) begin
            int hi;
            int d;
            int e;
            bit shape_ok;
            hi = 0;
            shape_ok = 1'b1;
            for (int k = 0; k < pe; k++) begin
                @(negedge clk);
                if (pwm_o) begin
                    hi++;
                    if (hi != k + 1) shape_ok = 1'b0;
                end
            end
            d = load_d(n, m, p);
            e = (d < pe) ? d : pe;
            if (d == 0)
                chk(hi == e, "R7 zero count stays low", hi, e);
            else if (d >= pe)
                chk(hi == e, "R8 full count stays high", hi, e);
            else
                chk(hi == e, "R3 per-period high count", hi, e);
            chk(shape_ok, "R4 contiguous run from period start", int'(shape_ok), 1);
            if (p < M) sum += hi;
        end
        if (n + 1 <= pe)
            chk(sum == M * n + m, "R5 frame total", sum, M * n + m);
    endtask

    // R2: window order across one frame.
    task automatic win_order(input int n, input int m);
        int cnt [M];
        start_cfg(6, n, m);
        for (int p = 0; p < M; p++) begin
            cnt[p] = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (pwm_o) cnt[p]++;
            end
        end
        for (int p = 0; p < M; p++)
            chk(cnt[p] == n + ((M - 1 - p) < m ? 1 : 0), "R2 window order", cnt[p],
                n + ((M - 1 - p) < m ? 1 : 0));
    endtask

    // R1: spacing of rising edges.
    task automatic rise_spacing(input int no);
        int last_rise;
        int nrise;
        bit prev;
        last_rise = -1;
        nrise = 0;
        prev = 1'b0;
        start_cfg(no, 3, 0);
        for (int i = 0; i < 4 * no + 1; i++) begin
            @(negedge clk);
            if (pwm_o && !prev) begin
                if (last_rise >= 0)
                    chk(i - last_rise == no, "R1 rise spacing", i - last_rise, no);
                last_rise = i;
                nrise++;
            end
            prev = pwm_o;
        end
        chk(nrise == 5, "R1 rise count", nrise, 5);
    endtask

    // R6: mid-period input change, then R9 reset while high.
    task automatic mid_change();
        bit smp [14];
        int h0;
        int h1;
        start_cfg(8, 3, 0);
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            smp[i] = pwm_o;
            if (i == 1) begin
                period_i    = PER_W'(5);
                duty_int_i  = INT_W'(4);
                duty_frac_i = FRAC_W'(0);
            end
        end
        h0 = 0;
        for (int i = 0; i < 8; i++) if (smp[i]) h0++;
        h1 = 0;
        for (int i = 8; i < 13; i++) if (smp[i]) h1++;
        chk(h0 == 3, "R6 running period keeps old count", h0, 3);
        chk(smp[8] == 1'b1, "R6 running period keeps old length", int'(smp[8]), 1);
        chk(h1 == 4, "R6 next period uses new count", h1, 4);
        chk(smp[13] == 1'b1, "R6 next period uses new length", int'(smp[13]), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(pwm_o == 1'b0, "R9 reset forces low while high", int'(pwm_o), 0);
    endtask

    initial begin
        int nos [6] = '{0, 1, 2, 3, 5, 8};
        foreach (nos[i]) begin
            for (int n = 0; n <= nos[i] + 1; n++) begin
                for (int m = 0; m < M; m++) begin
                    run_cfg(nos[i], n, m, M + 1);
                end
            end
        end
        win_order(2, 1);
        win_order(2, M - 1);
        rise_spacing(7);
        mid_change();
        run_cfg(4000, 1000, 1, M + 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule